// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers a parameterised number of external interrupt lines (64 by default) into one interrupt output for a processor. Each line first passes through a two-stage synchroniser. A small per-line state machine then decides whether the line is pending. The line can detect an edge or a level, and software picks which polarity counts as active. The block ORs together the pending lines that software has left unmasked and whose domain enable is set. That OR is registered and drives the single output `irq_out`.

Software sees a flat 32-bit register bus that carries an address, a write strobe, write data and combinational read data. Each register group packs 32 lines per word, and the block has `NUM_LINES/32` words per group. Mask, sensitivity and polarity each have a read-only value register and two write-only aliases: one sets bits and the other clears them. A write-one-to-clear acknowledge word clears pending lines. The domain-enable words are read/write.

Each line runs a two-state machine with states `LN_IDLE` and `LN_PEND` and these transitions:

| Transition | From | To | Mode | Condition |
|---|---|---|---|---|
| FIRE_EDGE | LN_IDLE | LN_PEND | edge | active edge seen |
| FIRE_LEVEL | LN_IDLE | LN_PEND | level | active level seen |
| ACK_CLEAR | LN_PEND | LN_IDLE | edge | acknowledge with no new edge in the same cycle |
| LEVEL_DROP | LN_PEND | LN_IDLE | level | level no longer active |

In every other case the line stays in its current state.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the status words read 0 and the mask words read all ones. The sensitivity, polarity and domain-enable words read 0, and `irq_out` is 0.
- R2: Line n sits in bit (n mod 32) of word (n/32) of each group. The word lies at the group base plus 4*(n/32). The group bases are:

  | Group | Base |
  |---|---|
  | status | 0x000 |
  | acknowledge | 0x040 |
  | mask value | 0x080 |
  | mask set | 0x0C0 |
  | mask clear | 0x100 |
  | sensitivity value | 0x140 |
  | sensitivity set | 0x180 |
  | sensitivity clear | 0x1C0 |
  | polarity value | 0x300 |
  | polarity set | 0x340 |
  | polarity clear | 0x380 |
  | domain enable | 0x400 |

- R3: A 1 bit written to a set alias sets only that line's configuration bit, and a 1 bit written to a clear alias clears only that bit. A 0 bit changes nothing.
- R4: In edge mode (sensitivity bit 0), a falling input edge makes the line pending when the polarity bit is 0, and a rising edge does so when the polarity bit is 1. An edge of the other direction has no effect. The line stays pending after the input returns to its idle level.
- R5: In edge mode, writing 1 to a line's acknowledge bit clears its pending status. Writing 0 bits leaves the pending status unchanged.
- R6: In level mode (sensitivity bit 1), the pending status follows the active level: low for polarity 0, high for polarity 1. An acknowledge does not clear a line whose level is still active. The pending status clears by itself once the level goes away.
- R7: An input change applied before clock edge k shows in the status word after edge k+2, and it does not show after edge k+1.
- R8: `irq_out` is registered. It is the OR over all lines of pending AND NOT mask AND domain enable, so a cleared domain-enable word or a set mask bit keeps the line's pending status off the output.
- R9: If an acknowledge and a new active edge reach a pending edge-mode line in the same cycle, the line stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | External interrupt lines, asynchronous |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is R9, where an acknowledge write and a fresh active edge land on the same clock edge. The bench produces it using the known three-edge input latency. It first makes line 2 pending and returns the input to idle. It then drives the falling edge at a negative clock edge and waits two rising edges. On the negative edge that follows, it raises the acknowledge write, so the write and the detected edge meet at the third rising edge. It then reads the status word to confirm the line is still pending.

// File: rtl/eic_pkg.sv
`timescale 1ns/1ps
package eic_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 12;
    localparam int GRP_W  = 6;

    typedef enum logic [0:0] {
        LN_IDLE = 1'b0,
        LN_PEND = 1'b1
    } ln_state_e;

    // register group index = byte address bits [11:6]
    localparam logic [GRP_W-1:0] GRP_STAT = 6'd0;
    localparam logic [GRP_W-1:0] GRP_ACK  = 6'd1;
    localparam logic [GRP_W-1:0] GRP_MASK = 6'd2;
    localparam logic [GRP_W-1:0] GRP_MSET = 6'd3;
    localparam logic [GRP_W-1:0] GRP_MCLR = 6'd4;
    localparam logic [GRP_W-1:0] GRP_SENS = 6'd5;
    localparam logic [GRP_W-1:0] GRP_SSET = 6'd6;
    localparam logic [GRP_W-1:0] GRP_SCLR = 6'd7;
    localparam logic [GRP_W-1:0] GRP_POL  = 6'd12;
    localparam logic [GRP_W-1:0] GRP_PSET = 6'd13;
    localparam logic [GRP_W-1:0] GRP_PCLR = 6'd14;
    localparam logic [GRP_W-1:0] GRP_DOM  = 6'd16;
endpackage

// File: rtl/eic_sync.sv
`timescale 1ns/1ps
module eic_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur  = cur_q;
    assign prev = prev_q;
endmodule

// File: rtl/eic_line.sv
`timescale 1ns/1ps
module eic_line
    import eic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cur,
    input  logic prev,
    input  logic lvl_mode,
    input  logic act_high,
    input  logic ack,
    output logic pend
);
    ln_state_e state_q, state_d;
    logic active, evt;

    always_comb begin
        active = (cur == act_high);
        evt    = act_high ? (cur & ~prev) : (~cur & prev);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: begin
                if (lvl_mode ? active : evt)
                    state_d = LN_PEND;               // FIRE_LEVEL / FIRE_EDGE
            end
            LN_PEND: begin
                if (lvl_mode) begin
                    if (!active) state_d = LN_IDLE;  // LEVEL_DROP
                end else if (ack && !evt) begin
                    state_d = LN_IDLE;               // ACK_CLEAR
                end
            end
            default: state_d = LN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend = (state_q == LN_PEND);
    end

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_mode && active) |=> pend);                      // R6
    AST_LEVEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_mode && !active) |=> !pend);                    // R6
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_mode && pend && !ack) |=> pend);               // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_mode && ack && !evt) |=> !pend);               // R5
    AST_ACK_RACE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_mode && evt) |=> pend);                        // R9
endmodule

// File: rtl/eic_regs.sv
`timescale 1ns/1ps
module eic_regs
    import eic_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [NUM_LINES-1:0] pend,
    output logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] lvl_mode,
    output logic [NUM_LINES-1:0] act_high,
    output logic [NUM_LINES-1:0] dom_en,
    output logic [NUM_LINES-1:0] ack
);
    localparam int WORDS = NUM_LINES / REG_W;

    logic [GRP_W-1:0]     grp;
    logic [3:0]           word_idx;
    logic                 word_ok;
    int unsigned          wbase;
    logic [NUM_LINES-1:0] mask_q, sens_q, pol_q, dom_q;

    always_comb begin
        grp      = bus_addr[ADDR_W-1:6];
        word_idx = bus_addr[5:2];
        word_ok  = (int'(word_idx) < WORDS);
        wbase    = word_ok ? 32'(word_idx) * 32'(REG_W) : 32'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            sens_q <= '0;
            pol_q  <= '0;
            dom_q  <= '0;
        end else if (bus_we && word_ok) begin
            case (grp)
                GRP_MSET: mask_q[wbase +: REG_W] <= mask_q[wbase +: REG_W] |  bus_wdata;
                GRP_MCLR: mask_q[wbase +: REG_W] <= mask_q[wbase +: REG_W] & ~bus_wdata;
                GRP_SSET: sens_q[wbase +: REG_W] <= sens_q[wbase +: REG_W] |  bus_wdata;
                GRP_SCLR: sens_q[wbase +: REG_W] <= sens_q[wbase +: REG_W] & ~bus_wdata;
                GRP_PSET: pol_q[wbase +: REG_W]  <= pol_q[wbase +: REG_W]  |  bus_wdata;
                GRP_PCLR: pol_q[wbase +: REG_W]  <= pol_q[wbase +: REG_W]  & ~bus_wdata;
                GRP_DOM:  dom_q[wbase +: REG_W]  <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        ack = '0;
        if (bus_we && word_ok && (grp == GRP_ACK))
            ack[wbase +: REG_W] = bus_wdata;
    end

    always_comb begin
        bus_rdata = '0;
        if (word_ok) begin
            case (grp)
                GRP_STAT: bus_rdata = pend[wbase +: REG_W];
                GRP_MASK: bus_rdata = mask_q[wbase +: REG_W];
                GRP_SENS: bus_rdata = sens_q[wbase +: REG_W];
                GRP_POL:  bus_rdata = pol_q[wbase +: REG_W];
                GRP_DOM:  bus_rdata = dom_q[wbase +: REG_W];
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign mask     = mask_q;
    assign lvl_mode = sens_q;
    assign act_high = pol_q;
    assign dom_en   = dom_q;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(mask_q));                        // R3
    AST_SENS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(sens_q));                        // R3
    AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pol_q));                         // R3
endmodule

// File: rtl/ext_irq_ctrl.sv
`timescale 1ns/1ps
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    output logic                 irq_out
);
    logic [NUM_LINES-1:0] cur, prev, pend, mask, lvl_mode, act_high, dom_en, ack;
    logic                 irq_q;

    eic_sync #(.W(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(irq_in), .cur(cur), .prev(prev)
    );

    eic_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend(pend),
        .mask(mask), .lvl_mode(lvl_mode), .act_high(act_high),
        .dom_en(dom_en), .ack(ack)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        eic_line u_line (
            .clk(clk), .rst_n(rst_n), .cur(cur[i]), .prev(prev[i]),
            .lvl_mode(lvl_mode[i]), .act_high(act_high[i]),
            .ack(ack[i]), .pend(pend[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend & ~mask & dom_en);
    end

    assign irq_out = irq_q;

    AST_IRQ_DOMAIN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_en == '0) |=> !irq_out);                        // R8
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> !irq_out);                          // R8
    AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |=> !irq_out);                               // R8
endmodule

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;
    localparam int N = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '1;
    logic [11:0]   bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [11:0] q_addr[$];
    logic [31:0] q_exp[$];
    bit          q_irq[$];
    string       q_tag[$];
    event        smp_ev;

    always #2 clk = ~clk;   // 250 MHz

    ext_irq_ctrl #(.NUM_LINES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    // driver side: push expected item, then trigger the monitor mid-cycle
    task automatic chk(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        q_addr.push_back(a); q_exp.push_back(e); q_irq.push_back(1'b0); q_tag.push_back(tag);
        #1 -> smp_ev;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        q_addr.push_back(12'h0); q_exp.push_back({31'd0, e}); q_irq.push_back(1'b1); q_tag.push_back(tag);
        #1 -> smp_ev;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop and compare
    initial begin
        forever begin
            @(smp_ev);
            while (q_exp.size() > 0) begin
                logic [11:0] a;
                logic [31:0] e, got;
                bit          is_irq;
                string       t;
                a = q_addr.pop_front(); e = q_exp.pop_front();
                is_irq = q_irq.pop_front(); t = q_tag.pop_front();
                got = is_irq ? {31'd0, irq_out} : bus_rdata;
                vectors++;
                if (got !== e) begin
                    miscompares++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", t, a, got, e);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(4);
        // R1 reset state
        chk(12'h000, 32'h0, "R1 status w0");
        chk(12'h004, 32'h0, "R1 status w1");
        chk(12'h080, 32'hFFFF_FFFF, "R1 mask w0");
        chk(12'h084, 32'hFFFF_FFFF, "R1 mask w1");
        chk(12'h140, 32'h0, "R1 sens w0");
        chk(12'h300, 32'h0, "R1 pol w0");
        chk(12'h400, 32'h0, "R1 dom w0");
        chk_irq(1'b0, "R1 irq_out");

        wr(12'h400, 32'hFFFF_FFFF);
        wr(12'h404, 32'hFFFF_FFFF);
        chk(12'h404, 32'hFFFF_FFFF, "R2 dom w1");

        // R3 set/clear aliases
        wr(12'h100, 32'h0000_0005);
        chk(12'h080, 32'hFFFF_FFFA, "R3 mask clear");
        wr(12'h0C0, 32'h0000_0001);
        chk(12'h080, 32'hFFFF_FFFB, "R3 mask set");
        wr(12'h0C0, 32'h0);
        chk(12'h080, 32'hFFFF_FFFB, "R3 zero write");
        chk(12'h084, 32'hFFFF_FFFF, "R3 other word untouched");

        // R7 latency + R4 falling edge on line 2
        @(negedge clk);
        irq_in[2] = 1'b0;
        chk(12'h000, 32'h0, "R7 after edge k");
        chk(12'h000, 32'h0, "R7 after edge k+1");
        chk(12'h000, 32'h4, "R7 after edge k+2");
        chk_irq(1'b1, "R8 irq unmasked");
        irq_in[2] = 1'b1;
        idle(5);
        chk(12'h000, 32'h4, "R4 edge stays pending");

        // R5 acknowledge
        wr(12'h040, 32'h0);
        chk(12'h000, 32'h4, "R5 zero ack");
        wr(12'h040, 32'h4);
        chk(12'h000, 32'h0, "R5 ack clears");
        idle(2);
        chk_irq(1'b0, "R8 irq drops");

        // R4 rising edge, line 35 (word 1 bit 3), R2 addressing
        wr(12'h344, 32'h8);
        wr(12'h104, 32'h8);
        chk(12'h304, 32'h8, "R2 pol w1");
        chk(12'h300, 32'h0, "R2 pol w0");
        @(negedge clk); irq_in[35] = 1'b0;
        idle(5);
        chk(12'h004, 32'h0, "R4 wrong direction ignored");
        @(negedge clk); irq_in[35] = 1'b1;
        idle(5);
        chk(12'h004, 32'h8, "R4 rising edge");
        chk(12'h000, 32'h0, "R2 word0 clean");
        wr(12'h044, 32'h8);
        chk(12'h004, 32'h0, "R5 ack word1");

        // R6 level mode, line 5 active low
        wr(12'h180, 32'h20);
        wr(12'h100, 32'h20);
        chk(12'h140, 32'h20, "R3 sens set");
        @(negedge clk); irq_in[5] = 1'b0;
        idle(4);
        chk(12'h000, 32'h20, "R6 level pending");
        wr(12'h040, 32'h20);
        chk(12'h000, 32'h20, "R6 ack ignored while active");
        chk_irq(1'b1, "R8 level irq");

        // R8 domain and mask gating
        wr(12'h400, 32'h0);
        idle(2);
        chk_irq(1'b0, "R8 domain off");
        chk(12'h000, 32'h20, "R8 status kept");
        wr(12'h400, 32'hFFFF_FFFF);
        idle(2);
        chk_irq(1'b1, "R8 domain on");
        wr(12'h0C0, 32'h20);
        idle(2);
        chk_irq(1'b0, "R8 masked");
        @(negedge clk); irq_in[5] = 1'b1;
        idle(4);
        chk(12'h000, 32'h0, "R6 level released");
        wr(12'h1C0, 32'h20);
        chk(12'h140, 32'h0, "R3 sens clear");

        // R9 acknowledge racing a new edge on line 2
        @(negedge clk); irq_in[2] = 1'b0;
        idle(4);
        irq_in[2] = 1'b1;
        idle(4);
        chk(12'h000, 32'h4, "R9 setup pending");
        @(negedge clk); irq_in[2] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 12'h040; bus_wdata = 32'h4; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        chk(12'h000, 32'h4, "R9 edge wins over ack");
        wr(12'h040, 32'h4);
        chk(12'h000, 32'h0, "R9 later ack clears");

        idle(2);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule